// File: doc/BRIEF.md
# Reuse-Hinted RRIP Replacement Controller

This block chooses eviction victims for one set-associative shared last-level cache that serves several cores, with four as the main configuration. Each way of each set has a 2-bit re-reference prediction value (RRPV). A value of 0 means the line is expected back soon. A value of 3 means it is expected back only in the distant future. Tag and data arrays stay outside the block. It sees only set and way indices, plus a hint bit that comes with each fill.

The private cache above supplies the hint. It says whether the line was touched again while it lived up there. A line that was reused is inserted one step short of distant, so it gets some time to prove itself. A line that was never reused is inserted as distant, so it becomes the next eviction candidate straight away and lines with real reuse stay resident longer. A hit promotes a line to 0.

A victim search works in this order:
1. Take any way that is not yet valid.
2. Otherwise take the lowest-indexed way at 3.
3. Otherwise age the whole set by one and look again.

The aging is written back to storage.

All commands share one port. The controller takes one command at a time and signals `ready` when it can accept the next.

Top module: `rrip_repl_ctrl`

## Requirements
- R1: After synchronous reset, `ready` is 1, `vic_done` is 0, and every way of every set is invalid, so a victim request on any set returns way 0.
- R2: A command is accepted only when `cmd_valid` and `ready` are both 1. From the cycle after acceptance until the command completes, `ready` is 0, and any command presented during that time is ignored.
- R3: A hit command (`cmd_op` = 0) sets the addressed way's RRPV to 0.
- R4: A fill command (`cmd_op` = 1) marks the way valid. It sets the RRPV to 2 when `cmd_reused` is 1 and to 3 when `cmd_reused` is 0.
- R5: A victim request (`cmd_op` = 2) on a set with an invalid way returns the lowest-indexed invalid way, with no aging.
- R6: If every way is valid and at least one has RRPV 3, the victim is the lowest-indexed way at 3.
- R7: If no way has RRPV 3, all RRPVs of the set are raised by one, once per cycle, until some way reaches 3. The raised values stay stored for later commands.
- R8: A hit or fill brings `ready` back 3 cycles after the accepting edge. A victim request raises `vic_done` for exactly one cycle, together with `ready`, 3 + A cycles after acceptance, where A (0..3) is the number of aging steps. `vic_way` is held between results.
- R9: While a set holds a line at RRPV 3, a stream of unreused fills into victim ways never evicts a line that was hit after its insertion.
- R10: Opcode 3 is a no-op. It is never accepted and leaves `ready` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 hit, 1 fill, 2 victim request, 3 no-op |
| cmd_set | input | SET_W | Set index |
| cmd_way | input | WAY_W | Way index for hit and fill |
| cmd_reused | input | 1 | Fill hint: line was reused in the upper cache |
| ready | output | 1 | Controller idle, command may be presented |
| vic_done | output | 1 | One-cycle pulse: `vic_way` is a fresh victim |
| vic_way | output | WAY_W | Chosen victim way |

## Verification
The RRPVs are hidden, so a corrupted counter shows up only at the ports. It appears on the next victim request to that set, either as a different way or as a different latency, because the number of aging steps adds one cycle each. For that reason every victim result is compared on both the way and the exact cycle of `vic_done`, against a bench model of all counters. A lost write-back of aging shows on the second consecutive request, which would age again instead of finishing at once. A command wrongly accepted while busy shows on the following victim request to the set it touched.

// File: rtl/rrip_pkg.sv
`timescale 1ns/1ps
package rrip_pkg;
  typedef enum logic [1:0] {
    OP_HIT    = 2'd0,
    OP_FILL   = 2'd1,
    OP_VICTIM = 2'd2,
    OP_NONE   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_EXEC = 2'd2
  } st_e;
endpackage

// File: rtl/rrip_set_mem.sv
`timescale 1ns/1ps
// Simple dual-port RRPV storage, registered read, one row per set.
module rrip_set_mem #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/rrip_first_pick.sv
`timescale 1ns/1ps
// Lowest-index set bit finder.
module rrip_first_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/rrip_repl_ctrl.sv
`timescale 1ns/1ps
module rrip_repl_ctrl
  import rrip_pkg::*;
#(
  parameter int NUM_SETS = 64,
  parameter int NUM_WAYS = 8,
  parameter int RRPV_W   = 2,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [SET_W-1:0] cmd_set,
  input  logic [WAY_W-1:0] cmd_way,
  input  logic             cmd_reused,
  output logic             ready,
  output logic             vic_done,
  output logic [WAY_W-1:0] vic_way
);
  localparam int VEC_W = NUM_WAYS * RRPV_W;
  localparam logic [RRPV_W-1:0] R_MAX   = '1;
  localparam logic [RRPV_W-1:0] R_REUSE = R_MAX - RRPV_W'(1);

  st_e              st;
  op_e              op_q;
  logic [SET_W-1:0] set_q;
  logic [WAY_W-1:0] way_q;
  logic             hint_q;
  logic [VEC_W-1:0] work, rd_vec, aged, upd, wr_vec;
  logic [NUM_WAYS-1:0] vld_work, distant;
  logic [NUM_WAYS-1:0] vld_arr [NUM_SETS];
  logic             wr_en, accept;
  logic             inv_found, dist_found;
  logic [WAY_W-1:0] inv_idx, dist_idx;
  logic             vic_done_q;
  logic [WAY_W-1:0] vic_way_q;

  assign ready    = (st == ST_IDLE);
  assign accept   = cmd_valid && ready && (op_e'(cmd_op) != OP_NONE);
  assign vic_done = vic_done_q;
  assign vic_way  = vic_way_q;

  // Per-way distant flag and one-step aging
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign distant[w] = (work[w*RRPV_W +: RRPV_W] == R_MAX);
    assign aged[w*RRPV_W +: RRPV_W] = work[w*RRPV_W +: RRPV_W] + RRPV_W'(1);
  end

  rrip_first_pick #(.N(NUM_WAYS)) u_pick_inv (
    .req(~vld_work), .found(inv_found), .idx(inv_idx)
  );
  rrip_first_pick #(.N(NUM_WAYS)) u_pick_dist (
    .req(distant), .found(dist_found), .idx(dist_idx)
  );

  // Single-way update for hit (promote) and fill (hinted insertion)
  always_comb begin
    upd = work;
    case (op_q)
      OP_HIT:  upd[way_q*RRPV_W +: RRPV_W] = '0;
      OP_FILL: upd[way_q*RRPV_W +: RRPV_W] = hint_q ? R_REUSE : R_MAX;
      default: ;
    endcase
  end

  always_comb begin
    wr_en  = 1'b0;
    wr_vec = upd;
    if (st == ST_EXEC) begin
      case (op_q)
        OP_HIT, OP_FILL: wr_en = 1'b1;
        OP_VICTIM: begin
          wr_vec = aged;
          wr_en  = !inv_found && !dist_found;
        end
        default: ;
      endcase
    end
  end

  rrip_set_mem #(.DEPTH(NUM_SETS), .WIDTH(VEC_W)) u_mem (
    .clk(clk), .rd_en(accept), .rd_addr(cmd_set), .rd_data(rd_vec),
    .wr_en(wr_en), .wr_addr(set_q), .wr_data(wr_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      op_q       <= OP_NONE;
      set_q      <= '0;
      way_q      <= '0;
      hint_q     <= 1'b0;
      work       <= '0;
      vld_work   <= '0;
      vic_done_q <= 1'b0;
      vic_way_q  <= '0;
      for (int s = 0; s < NUM_SETS; s++) vld_arr[s] <= '0;
    end else begin
      vic_done_q <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          op_q   <= op_e'(cmd_op);
          set_q  <= cmd_set;
          way_q  <= cmd_way;
          hint_q <= cmd_reused;
          st     <= ST_LOAD;
        end
        ST_LOAD: begin
          work     <= rd_vec;
          vld_work <= vld_arr[set_q];
          st       <= ST_EXEC;
        end
        ST_EXEC: begin
          if (op_q == OP_VICTIM) begin
            if (inv_found) begin
              vic_done_q <= 1'b1;
              vic_way_q  <= inv_idx;
              st         <= ST_IDLE;
            end else if (dist_found) begin
              vic_done_q <= 1'b1;
              vic_way_q  <= dist_idx;
              st         <= ST_IDLE;
            end else begin
              work <= aged;
            end
          end else begin
            if (op_q == OP_FILL) vld_arr[set_q][way_q] <= 1'b1;
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rrip_repl_chk.sv
`timescale 1ns/1ps
module rrip_repl_chk #(
  parameter int WAY_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic             ready,
  input logic             vic_done,
  input logic [WAY_W-1:0] vic_way
);
  logic [3:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst || ready) busy_cnt <= '0;
    else if (busy_cnt != 4'hF) busy_cnt <= busy_cnt + 4'd1;
  end

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ready && !vic_done));

  a_r2_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && ready && cmd_op != 2'd3) |=> !ready);

  a_r10_noop_idle: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && ready && cmd_op == 2'd3) |=> (ready && !vic_done));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    vic_done |=> !vic_done);

  a_r8_done_ready: assert property (@(posedge clk) disable iff (rst)
    vic_done |-> ready);

  a_r8_way_held: assert property (@(posedge clk) disable iff (rst)
    !ready |=> (vic_done || $stable(vic_way)));

  a_r7_aging_bound: assert property (@(posedge clk) disable iff (rst)
    busy_cnt <= 4'd5);
endmodule

bind rrip_repl_ctrl rrip_repl_chk #(.WAY_W(WAY_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .ready(ready), .vic_done(vic_done), .vic_way(vic_way)
);

// File: tb/sim_rrip_repl_ctrl.sv
`timescale 1ns/1ps
module sim_rrip_repl_ctrl;
  localparam int NS = 64;
  localparam int NW = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd3;
  logic [5:0] cmd_set = '0;
  logic [2:0] cmd_way = '0;
  logic       cmd_reused = 1'b0;
  logic       ready, vic_done;
  logic [2:0] vic_way;

  int checks = 0;
  int errors = 0;
  int m_rr [NS][NW];
  bit m_v  [NS][NW];

  always #4 clk = ~clk;

  rrip_repl_ctrl #(.NUM_SETS(NS), .NUM_WAYS(NW), .RRPV_W(2)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_set(cmd_set), .cmd_way(cmd_way), .cmd_reused(cmd_reused),
    .ready(ready), .vic_done(vic_done), .vic_way(vic_way)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input int s, input int w,
                       input bit h, output int cyc);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_set = 6'(s); cmd_way = 3'(w); cmd_reused = h;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 1;
    while (!ready && cyc < 30) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic do_hit(input int s, input int w);
    int cyc;
    issue(2'd0, s, w, 1'b0, cyc);
    m_rr[s][w] = 0;
    chk(cyc == 3, "R8 hit latency", cyc, 3);
  endtask

  task automatic do_fill(input int s, input int w, input bit h);
    int cyc;
    issue(2'd1, s, w, h, cyc);
    m_rr[s][w] = h ? 2 : 3;
    m_v[s][w]  = 1'b1;
    chk(cyc == 3, "R8 fill latency", cyc, 3);
  endtask

  // Model of victim choice: invalid first, then lowest distant, aging otherwise.
  task automatic model_victim(input int s, output int w, output int a);
    w = -1; a = 0;
    for (int i = 0; i < NW; i++) if (!m_v[s][i] && w < 0) w = i;
    while (w < 0) begin
      for (int i = 0; i < NW; i++) if (m_rr[s][i] == 3 && w < 0) w = i;
      if (w < 0) begin
        for (int i = 0; i < NW; i++) m_rr[s][i]++;
        a++;
      end
    end
  endtask

  task automatic do_victim(input int s, input string tag, output int vw);
    int cyc, ew, ea;
    model_victim(s, ew, ea);
    issue(2'd2, s, 0, 1'b0, cyc);
    chk(vic_done == 1'b1, "R8 done pulse with ready", int'(vic_done), 1);
    chk(int'(vic_way) == ew, tag, int'(vic_way), ew);
    chk(cyc == 3 + ea, "R7/R8 victim latency", cyc, 3 + ea);
    vw = int'(vic_way);
    @(negedge clk);
    chk(vic_done == 1'b0, "R8 single-cycle done", int'(vic_done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int vw, cyc;
    void'($urandom(32'h5EED_1234));
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin m_rr[s][w] = 0; m_v[s][w] = 1'b0; end

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ready == 1'b1, "R1 ready after reset", int'(ready), 1);
    chk(vic_done == 1'b0, "R1 done low after reset", int'(vic_done), 0);
    do_victim(0, "R1 empty set gives way 0", vw);

    // R5: partially filled set returns lowest invalid way
    do_fill(2, 0, 1'b0); do_fill(2, 1, 1'b1); do_fill(2, 3, 1'b0);
    do_victim(2, "R5 lowest invalid way", vw);

    // R10: no-op is ignored
    issue(2'd3, 2, 2, 1'b1, cyc);
    chk(cyc == 1 && ready, "R10 no-op not accepted", cyc, 1);
    do_victim(2, "R10 set unchanged after no-op", vw);

    // R2: a fill presented while busy must be ignored
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_set = 6'd1; cmd_way = 3'd0;
    @(negedge clk);
    cmd_op = 2'd1; cmd_set = 6'd5; cmd_way = 3'd0; cmd_reused = 1'b1;
    chk(ready == 1'b0, "R2 busy after accept", int'(ready), 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!ready) @(negedge clk);
    m_rr[1][0] = 0;
    do_victim(5, "R2 command while busy ignored", vw);

    // R4: hinted vs unhinted insertion
    for (int w = 0; w < NW; w++) do_fill(20, w, w < 4);
    do_victim(20, "R4 unreused fill is distant", vw);
    for (int w = 0; w < NW; w++) do_fill(21, w, 1'b1);
    do_victim(21, "R4 reused fill needs one aging step", vw);

    // R3 + R7: all promoted -> three aging steps, then stored
    for (int w = 0; w < NW; w++) do_fill(22, w, 1'b0);
    for (int w = 0; w < NW; w++) do_hit(22, w);
    do_victim(22, "R3/R7 full aging from 0", vw);
    do_victim(22, "R7 aging kept in storage", vw);

    // R6: lowest distant way
    for (int w = 0; w < NW; w++) do_fill(23, w, 1'b0);
    do_hit(23, 0); do_hit(23, 1);
    do_victim(23, "R6 lowest distant way", vw);

    // R9: scan of unreused fills never evicts hit lines
    for (int w = 0; w < NW; w++) do_fill(30, w, 1'b0);
    do_hit(30, 0); do_hit(30, 2);
    for (int k = 0; k < 20; k++) begin
      do_victim(30, "R9 victim matches model", vw);
      chk(vw != 0 && vw != 2, "R9 hit line kept", vw, 1);
      do_fill(30, vw, 1'b0);
    end

    // Random mix on sets 8..15
    for (int k = 0; k < 400; k++) begin
      int s, op, w;
      s  = 8 + int'($urandom_range(0, 7));
      op = int'($urandom_range(0, 2));
      w  = int'($urandom_range(0, NW - 1));
      if (op == 0) do_hit(s, w);
      else if (op == 1) do_fill(s, w, 1'($urandom_range(0, 1)));
      else begin
        do_victim(s, "R5/R6/R7 random victim", vw);
        do_fill(s, vw, 1'($urandom_range(0, 1)));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule